// File: doc/BRIEF.md
# Posted-Write 32-to-16 Peripheral Bus Bridge

This block sits between a CPU-side request port with a 32-bit data path and a slow external peripheral bus that is only 16 bits wide. It does not look at the access size the CPU asks for. Every access, of any size, becomes one 32-bit transfer split into two 16-bit bus cycles. The upper half goes first, at the request address with bit 0 cleared. The lower half follows at that address plus 2. Bit 1 is left as given, so a request at an address ending in 2 moves the unaligned word that spans offsets 2 to 5.

Reads stall the CPU until both halves have come back. Writes are posted. The bridge latches the word, answers the CPU on the next cycle and runs the two bus writes in the background while it drives a busy flag. While that flag is high, the bridge handles new requests in two ways:

- A further write is acknowledged but discarded.
- A read from any address returns the latched write word and does not touch the bus.

The CPU issues a one-cycle `cpu_req` and waits for the one-cycle `cpu_ready` before it issues the next request. On the external side, `ext_strobe` stays high for each half until the device pulses `ext_ack`.

Top module: `ext_bridge32to16`

## Requirements
- R1: After reset, `cpu_ready`, `busy` and `ext_strobe` are all 0.
- R2: Every request that is not served from the pending write produces exactly two external cycles. This holds for every value of `cpu_size` (0 to 3).
- R3: The first external cycle uses address `{cpu_addr[AW-1:1],1'b0}` and carries bits 31:16 of the word. The second uses that address plus 2 and carries bits 15:0. Address bit 1 is never cleared.
- R4: A read returns the first half's `ext_rdata` in `cpu_rdata[31:16]` and the second half's `ext_rdata` in `cpu_rdata[15:0]`. `cpu_ready` is a single-cycle pulse.
- R5: A read raises `cpu_ready` only after the second half has been acknowledged, one cycle after that acknowledge.
- R6: A write accepted while not busy raises `cpu_ready` and `busy` in the cycle after `cpu_req`, before any external acknowledge.
- R7: `busy` stays 1 through the acknowledge of the second external write and is 0 in the following cycle.
- R8: A write requested while `busy` is 1 gets a `cpu_ready` pulse but causes no external cycle. It also leaves the pending word unchanged.
- R9: A read requested while `busy` is 1 returns the latched write word one cycle later and causes no external cycle.
- R10: While `ext_strobe` is 1 and `ext_ack` is 0, the next cycle keeps `ext_strobe` at 1 and keeps `ext_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle request pulse |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Requested access size, ignored |
| cpu_addr | input | AW | Byte address of the request |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Posted write still in progress |
| ext_strobe | output | 1 | External cycle request, held until ack |
| ext_we | output | 1 | External cycle is a write |
| ext_addr | output | AW | External half-word address |
| ext_wdata | output | 16 | External write half |
| ext_rdata | input | 16 | External read half |
| ext_ack | input | 1 | External cycle acknowledge |

## Verification
The bench targets the following corner cases:

- **Misaligned addresses.** It reads at addresses ending in 2 and 3. A bridge that also cleared bit 1 would fetch offsets 0 and 2, and the scoreboard would flag the wrong external addresses.
- **Size independence.** It varies `cpu_size` on identical requests. A design that honoured the size would shorten the transfer, which shows up as a missing external cycle.
- **Requests during a posted write.** With a slow acknowledge it issues a read and a second write while the first write is still pending. A design that let either one reach the bus would produce an unexpected external transaction. A design that accepted the second write would change the word that is read back afterwards.
- **Timing of `busy`.** The bench checks `busy` right at the final write acknowledge and again one cycle later. A premature or sticky flag fails there.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HI,
        ST_RD_LO,
        ST_WR_HI,
        ST_WR_LO
    } bus_state_e;
endpackage

// File: rtl/bridge_half_sel.sv
// Selects the external address and write half for the current phase.
module bridge_half_sel
    import bridge_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     base_addr,
    input  logic [WORD_W-1:0] word,
    input  logic              phase_lo,
    output logic [AW-1:0]     half_addr,
    output logic [HALF_W-1:0] half_data
);
    localparam logic [AW-1:0] STEP = AW'(HALF_W / 8);

    always_comb begin
        half_addr = phase_lo ? (base_addr + STEP) : base_addr;
        half_data = phase_lo ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
    end
endmodule

// File: rtl/bridge_ctrl.sv
// Sequencer: CPU handshake, posted-write latch, two-phase bus control.
module bridge_ctrl
    import bridge_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              busy,
    output logic              ext_strobe,
    output logic              ext_we,
    input  logic [HALF_W-1:0] ext_rdata,
    input  logic              ext_ack,
    output logic              phase_lo,
    output logic [AW-1:0]     base_addr,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        bus_state_e        st;
        logic [AW-1:0]     base;
        logic [WORD_W-1:0] wdat;
        logic [HALF_W-1:0] hi_buf;
        logic [WORD_W-1:0] rdata;
        logic              ready;
    } ctrl_t;

    ctrl_t q, d;

    logic unused_addr0;
    assign unused_addr0 = cpu_addr[0];

    logic busy_w;
    assign busy_w = (q.st == ST_WR_HI) || (q.st == ST_WR_LO);

    always_comb begin
        d = q;
        d.ready = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.base = {cpu_addr[AW-1:1], 1'b0};
                    if (cpu_we) begin
                        d.wdat  = cpu_wdata;
                        d.ready = 1'b1;
                        d.st    = ST_WR_HI;
                    end else begin
                        d.st = ST_RD_HI;
                    end
                end
            end
            ST_RD_HI: begin
                if (ext_ack) begin
                    d.hi_buf = ext_rdata;
                    d.st     = ST_RD_LO;
                end
            end
            ST_RD_LO: begin
                if (ext_ack) begin
                    d.rdata = {q.hi_buf, ext_rdata};
                    d.ready = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            ST_WR_HI, ST_WR_LO: begin
                if (ext_ack) begin
                    d.st = (q.st == ST_WR_HI) ? ST_WR_LO : ST_IDLE;
                end
                if (cpu_req) begin
                    d.ready = 1'b1;
                    if (!cpu_we) begin
                        d.rdata = q.wdat;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cpu_rdata  = q.rdata;
    assign cpu_ready  = q.ready;
    assign busy       = busy_w;
    assign ext_strobe = (q.st != ST_IDLE);
    assign ext_we     = busy_w;
    assign phase_lo   = (q.st == ST_RD_LO) || (q.st == ST_WR_LO);
    assign base_addr  = q.base;
    assign word       = q.wdat;

    AST_WRITE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !busy) |=> (busy && cpu_ready)); // R6
    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_ack && phase_lo) |=> !busy); // R7
    AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && busy) |=> (cpu_ready && $stable(word))); // R8
    AST_READ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && busy) |=> (cpu_ready && cpu_rdata == $past(word))); // R9
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R4
endmodule

// File: rtl/ext_bridge32to16.sv
module ext_bridge32to16
    import bridge_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              busy,
    output logic              ext_strobe,
    output logic              ext_we,
    output logic [AW-1:0]     ext_addr,
    output logic [HALF_W-1:0] ext_wdata,
    input  logic [HALF_W-1:0] ext_rdata,
    input  logic              ext_ack
);
    // Requested size has no effect on the transfer.
    logic unused_size;
    assign unused_size = ^cpu_size;

    logic              phase_lo;
    logic [AW-1:0]     base_addr;
    logic [WORD_W-1:0] word;

    bridge_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .busy       (busy),
        .ext_strobe (ext_strobe),
        .ext_we     (ext_we),
        .ext_rdata  (ext_rdata),
        .ext_ack    (ext_ack),
        .phase_lo   (phase_lo),
        .base_addr  (base_addr),
        .word       (word)
    );

    bridge_half_sel #(.AW(AW)) u_half (
        .base_addr (base_addr),
        .word      (word),
        .phase_lo  (phase_lo),
        .half_addr (ext_addr),
        .half_data (ext_wdata)
    );

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_strobe && !ext_ack) |=> (ext_strobe && $stable(ext_addr))); // R10
    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ext_strobe |-> (ext_addr[0] == 1'b0)); // R3
endmodule

// File: tb/ext_bridge32to16_tb.sv
`timescale 1ns/1ps
module ext_bridge32to16_tb;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        busy;
    logic        ext_strobe;
    logic        ext_we;
    logic [31:0] ext_addr;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata = '0;
    logic        ext_ack = 1'b0;

    always #4 clk = ~clk;

    ext_bridge32to16 #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .busy(busy),
        .ext_strobe(ext_strobe), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int lat = 1;
    bit rd_lo_seen = 0;

    typedef struct { logic [31:0] a; logic we; logic [15:0] d; bit last; string tag; } bus_exp_t;
    typedef struct { bit is_rd; bit via_bus; logic [31:0] d; string tag; } rsp_exp_t;
    bus_exp_t bq[$];
    rsp_exp_t rq[$];
    logic [15:0] mem [logic [31:0]];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mget(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // External device model: checks each transaction against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ext_strobe) begin
                repeat (lat - 1) @(negedge clk);
                if (bq.size() == 0) begin
                    check(0, "R8/R9 unexpected bus cycle", ext_addr, 32'h0);
                end else begin
                    bus_exp_t e;
                    e = bq.pop_front();
                    check(ext_addr == e.a, {e.tag, " R3 addr"}, ext_addr, e.a);
                    check(ext_we == e.we, {e.tag, " R2 dir"}, 32'(ext_we), 32'(e.we));
                    if (e.we) check(ext_wdata == e.d, {e.tag, " R3 wdata"}, 32'(ext_wdata), 32'(e.d));
                    if (e.we && e.last) check(busy == 1'b1, "R7 busy at last ack", 32'(busy), 32'h1);
                end
                if (ext_we) mem[ext_addr] = ext_wdata;
                ext_rdata = mget(ext_addr);
                ext_ack = 1'b1;
                @(negedge clk);
                ext_ack = 1'b0;
                if (ext_we && !ext_strobe) check(busy == 1'b0, "R7 busy cleared", 32'(busy), 32'h0);
                if (!ext_we && !ext_strobe) rd_lo_seen = 1;
            end
        end
    end

    // Monitor: pops expected responses on each ready pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cpu_ready) begin
                if (rq.size() == 0) begin
                    check(0, "R4 unexpected ready", 32'h1, 32'h0);
                end else begin
                    rsp_exp_t r;
                    r = rq.pop_front();
                    if (r.is_rd) check(cpu_rdata == r.d, {r.tag, " rdata"}, cpu_rdata, r.d);
                    if (r.is_rd && r.via_bus) check(rd_lo_seen, "R5 ready after second ack", 32'(rd_lo_seen), 32'h1);
                end
            end
        end
    end

    task automatic push_bus(input logic [31:0] a, input logic we, input logic [31:0] w, input string tag);
        logic [31:0] b;
        b = {a[31:1], 1'b0};
        bq.push_back('{a: b, we: we, d: w[31:16], last: 0, tag: tag});
        bq.push_back('{a: b + 32'd2, we: we, d: w[15:0], last: 1, tag: tag});
    endtask

    task automatic issue(input logic we, input logic [31:0] a, input logic [31:0] w, input logic [1:0] sz);
        @(negedge clk);
        rd_lo_seen = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = w; cpu_size = sz;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready) @(negedge clk);
    endtask

    task automatic do_read(input logic [31:0] a, input logic [1:0] sz, input string tag);
        logic [31:0] b, exp;
        b = {a[31:1], 1'b0};
        exp = {mget(b), mget(b + 32'd2)};
        push_bus(a, 1'b0, 32'h0, tag);
        rq.push_back('{is_rd: 1, via_bus: 1, d: exp, tag: tag});
        issue(1'b0, a, 32'h0, sz);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] w, input logic [1:0] sz, input string tag);
        push_bus(a, 1'b1, w, tag);
        rq.push_back('{is_rd: 0, via_bus: 1, d: 32'h0, tag: tag});
        issue(1'b1, a, w, sz);
        check(busy == 1'b1, "R6 busy with ready", 32'(busy), 32'h1);
    endtask

    task automatic wait_idle();
        while (busy || bq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[32'h1000_0000 + 32'(2 * i)] = 16'h1100 + 16'(i * 16'h0101);
        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b0, "R1 ready", 32'(cpu_ready), 32'h0);
        check(busy == 1'b0, "R1 busy", 32'(busy), 32'h0);
        check(ext_strobe == 1'b0, "R1 strobe", 32'(ext_strobe), 32'h0);
        rst_n = 1'b1;

        // Aligned, misaligned-by-2 and odd-address reads, all sizes (R2, R3, R4, R5)
        do_read(32'h1000_0000, 2'd2, "R4 aligned read");
        do_read(32'h1000_0002, 2'd1, "R3 bit1 kept read");
        do_read(32'h1000_0003, 2'd0, "R3 bit0 cleared read");
        do_read(32'h1000_0008, 2'd3, "R2 size3 read");
        wait_idle();

        // Posted writes, fast ack (R6, R7)
        lat = 1;
        do_write(32'h2000_0010, 32'hCAFE_F00D, 2'd2, "R6 write");
        wait_idle();
        do_read(32'h2000_0010, 2'd0, "R2 readback");
        do_write(32'h2000_0022, 32'h1234_5678, 2'd1, "R3 write at +2");
        wait_idle();
        do_read(32'h2000_0020, 2'd2, "R3 readback below");
        do_read(32'h2000_0022, 2'd2, "R3 readback at");

        // Requests during a pending write, slow ack (R8, R9)
        lat = 8;
        do_write(32'h3000_0000, 32'hA5A5_5A5A, 2'd2, "R7 slow write");
        rq.push_back('{is_rd: 1, via_bus: 0, d: 32'hA5A5_5A5A, tag: "R9 read while busy"});
        issue(1'b0, 32'h1000_0000, 32'h0, 2'd2);
        rq.push_back('{is_rd: 0, via_bus: 0, d: 32'h0, tag: "R8 write while busy"});
        issue(1'b1, 32'h3000_0000, 32'hDEAD_BEEF, 2'd2);
        check(busy == 1'b1, "R8 still busy", 32'(busy), 32'h1);
        wait_idle();
        lat = 2;
        do_read(32'h3000_0000, 2'd2, "R8 dropped write absent");
        wait_idle();
        check(rq.size() == 0 && bq.size() == 0, "R2 scoreboard drained", 32'(rq.size() + bq.size()), 32'h0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule